// File: doc/BRIEF.md
# DDR1/DDR2 Power-Up Command Sequencer

This block walks a DDR1 or DDR2 memory device through its power-up initialisation. A single start pulse latches the configuration: memory generation, DDR clock in MHz, reference crystal (25 or 40 MHz) and an optional forced CAS latency. The block then issues a fixed series of precharge-all, auto-refresh and mode-register-set commands to a memory controller. Each command uses a valid/acknowledge handshake and waits for its acknowledge before the next one is presented. Once the last command is acknowledged, the block enables periodic refresh and holds a done flag.

The CAS latency comes from the DDR clock unless a fixed value is forced. A small set of timing counts is derived from a clock figure. That figure is never allowed below a safe floor, so slow clocks still get conservative timings. These counts are the write recovery carried in the DDR2 mode register, the precharge period and the refresh-cycle time. The timings are held on outputs for the timing registers of the controller.

Top module: `ddr_init_seq`

## Requirements
- R1: After reset no command is valid, and busy, done and refresh enable are all low.
- R2: With no forced CAS, DDR1 selects CAS latency 2 for a clock of 266 MHz or less and 3 above it.
- R3: With no forced CAS, DDR2 selects CAS latency 3 up to 400 MHz, 4 up to 533, 5 up to 666, 6 up to 800 and 7 above 800.
- R4: When the forced-CAS enable is high at start, the forced value is used as the CAS latency whatever the clock.
- R5: The DDR1 order is: precharge-all, EMR (code 0, DLL on), MR with DLL reset (code 0x103), precharge-all, auto-refresh, auto-refresh, final MR. Kind codes are 1 for precharge-all, 2 for auto-refresh and 3 for a mode write. The bank select is 0 for MR, 1 for EMR, 2 for EMR2 and 3 for EMR3.
- R6: The DDR2 order has three additions to the DDR1 order. EMR2 (code 0) and then EMR3 (code 0) come directly after the first precharge-all. The final MR is followed by an EMR with the OCD default code 0x782 and then an EMR with the OCD exit code 0x402.
- R7: Mode code fields:
  - Final MR: bits [2:0] = 3 (burst of 8) and bits [6:4] = CAS latency.
  - DDR2 only: bits [11:9] = write recovery minus one. Write recovery is (15·C + 1000)/2000, saturated at 8.
  - C is the clamped clock of R10.
- R8: A presented command, with its kind, bank and code, stays unchanged until it is acknowledged. Exactly one step is taken per acknowledge, whatever the acknowledge latency.
- R9: On the edge that accepts the final acknowledge, done and refresh enable rise together. The refresh period is 312 with a 40 MHz crystal and 195 with a 25 MHz crystal. No command is presented while done is high.
- R10: The clamped clock C is the DDR clock raised to at least 400 MHz for DDR1 and 533 MHz for DDR2. The precharge count is (15·C+500)/1000, saturated at 15. The refresh-cycle count is (T·C+500)/1000, saturated at 63, with T = 75 for DDR1 and 120 for DDR2.
- R11: A start pulse while busy is ignored. Inputs are latched only when a sequence starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start pulse, accepted when not busy |
| is_ddr2_i | input | 1 | 1 selects DDR2, 0 selects DDR1 |
| clk_mhz_i | input | 12 | DDR clock in MHz |
| xtal_40_i | input | 1 | 1 for a 40 MHz crystal, 0 for 25 MHz |
| cas_fix_en_i | input | 1 | Use the forced CAS latency |
| cas_fix_i | input | 3 | Forced CAS latency |
| cmd_valid_o | output | 1 | Command presented |
| cmd_kind_o | output | 2 | 1 precharge-all, 2 auto-refresh, 3 mode write |
| cmd_bank_o | output | 2 | Mode register select: 0 MR, 1 EMR, 2 EMR2, 3 EMR3 |
| cmd_data_o | output | 13 | Mode register code |
| cmd_ack_i | input | 1 | Controller accepts the presented command |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | Sequence finished |
| ref_en_o | output | 1 | Periodic refresh enabled |
| ref_period_o | output | 10 | Refresh period in crystal cycles |
| cas_lat_o | output | 3 | CAS latency in use |
| trp_cyc_o | output | 4 | Precharge period in clock cycles |
| trfc_cyc_o | output | 6 | Refresh-cycle time in clock cycles |

## Verification
The assertions assume the controller raises acknowledge only while a command is valid. They also assume start is a pulse that the environment may repeat at any time, including mid-sequence.

The bench's responder sets acknowledge for one cycle and only when it sees a command waiting. It can delay that acknowledge by a chosen number of cycles, which exercises the hold behaviour.

The single deliberate start pulse sent mid-sequence carries a changed configuration. This shows that the pulse and the changed inputs are both ignored.

// File: rtl/ddr_init_pkg.sv
package ddr_init_pkg;

  typedef enum logic [1:0] {
    CMD_NONE   = 2'd0,
    CMD_PREALL = 2'd1,
    CMD_AREF   = 2'd2,
    CMD_MODE   = 2'd3
  } cmd_kind_e;

  localparam logic [1:0] BANK_MR   = 2'd0;
  localparam logic [1:0] BANK_EMR  = 2'd1;
  localparam logic [1:0] BANK_EMR2 = 2'd2;
  localparam logic [1:0] BANK_EMR3 = 2'd3;

  localparam int MODE_W = 13;

  // mode register field placement
  localparam logic [MODE_W-1:0] MR_BL8      = 13'h003;
  localparam logic [MODE_W-1:0] MR_DLL_RST  = 13'h100;
  localparam int                MR_CAS_LSB  = 4;
  localparam int                MR_WR_LSB   = 9;
  localparam logic [MODE_W-1:0] EMR_WEAK    = 13'h002;
  localparam logic [MODE_W-1:0] EMR_OCD_DEF = 13'h380;
  localparam logic [MODE_W-1:0] EMR_NDQS    = 13'h400;

  localparam int TRP_NS      = 15;
  localparam int TWR_NS      = 15;
  localparam int TRFC1_NS    = 75;
  localparam int TRFC2_NS    = 120;

  // rounded ns-to-cycles with field saturation
  function automatic int unsigned ns_to_cyc(int unsigned ns, int unsigned mhz,
                                            int unsigned sat);
    int unsigned t;
    t = (ns * mhz + 500) / 1000;
    return (t > sat) ? sat : t;
  endfunction

endpackage

// File: rtl/ddr_cas_sel.sv
module ddr_cas_sel #(
  parameter int CLK_W        = 12,
  parameter int DDR1_MIN_MHZ = 400,
  parameter int DDR2_MIN_MHZ = 533
) (
  input  logic             is_ddr2_i,
  input  logic [CLK_W-1:0] clk_mhz_i,
  input  logic             cas_fix_en_i,
  input  logic [2:0]       cas_fix_i,
  output logic [2:0]       cas_o,
  output logic [CLK_W-1:0] clk_eff_o
);
  localparam logic [CLK_W-1:0] MIN1 = CLK_W'(DDR1_MIN_MHZ);
  localparam logic [CLK_W-1:0] MIN2 = CLK_W'(DDR2_MIN_MHZ);

  logic [2:0] cas_auto;

  always_comb begin
    if (!is_ddr2_i) begin
      cas_auto = (clk_mhz_i <= CLK_W'(266)) ? 3'd2 : 3'd3;
    end else if (clk_mhz_i <= CLK_W'(400)) begin
      cas_auto = 3'd3;
    end else if (clk_mhz_i <= CLK_W'(533)) begin
      cas_auto = 3'd4;
    end else if (clk_mhz_i <= CLK_W'(666)) begin
      cas_auto = 3'd5;
    end else if (clk_mhz_i <= CLK_W'(800)) begin
      cas_auto = 3'd6;
    end else begin
      cas_auto = 3'd7;
    end
  end

  assign cas_o = cas_fix_en_i ? cas_fix_i : cas_auto;

  always_comb begin
    if (is_ddr2_i) clk_eff_o = (clk_mhz_i < MIN2) ? MIN2 : clk_mhz_i;
    else           clk_eff_o = (clk_mhz_i < MIN1) ? MIN1 : clk_mhz_i;
  end

endmodule

// File: rtl/ddr_timing_calc.sv
module ddr_timing_calc
  import ddr_init_pkg::*;
#(
  parameter int CLK_W  = 12,
  parameter int TRP_W  = 4,
  parameter int TRFC_W = 6,
  parameter int WR_MAX = 8
) (
  input  logic              is_ddr2_i,
  input  logic [CLK_W-1:0]  clk_eff_i,
  output logic [TRP_W-1:0]  trp_o,
  output logic [TRFC_W-1:0] trfc_o,
  output logic [3:0]        wr_o
);
  localparam int unsigned TRP_MAX  = (1 << TRP_W) - 1;
  localparam int unsigned TRFC_MAX = (1 << TRFC_W) - 1;

  int unsigned mhz;
  int unsigned wr_raw;

  assign mhz = int'(clk_eff_i);

  always_comb begin
    trp_o  = TRP_W'(ns_to_cyc(TRP_NS, mhz, TRP_MAX));
    trfc_o = TRFC_W'(ns_to_cyc(is_ddr2_i ? TRFC2_NS : TRFC1_NS, mhz, TRFC_MAX));
    wr_raw = (TWR_NS * mhz + 1000) / 2000;
    wr_o   = (wr_raw > WR_MAX) ? 4'(WR_MAX) : 4'(wr_raw);
  end

endmodule

// File: rtl/ddr_cmd_seq.sv
module ddr_cmd_seq
  import ddr_init_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              go_i,
  input  logic              is_ddr2_i,
  input  logic [2:0]        cas_i,
  input  logic [3:0]        wr_i,
  input  logic              ack_i,
  output logic              valid_o,
  output logic [1:0]        kind_o,
  output logic [1:0]        bank_o,
  output logic [MODE_W-1:0] data_o,
  output logic              busy_o,
  output logic              done_o,
  output logic              fin_o
);
  typedef enum logic [3:0] {
    ST_IDLE, ST_PRE0, ST_EMR2, ST_EMR3, ST_EMR_DLL, ST_MR_RST, ST_PRE1,
    ST_AREF0, ST_AREF1, ST_MR_FIN, ST_OCD_DEF, ST_OCD_EXIT, ST_DONE
  } st_e;

  st_e st_q, st_d;
  cmd_kind_e kind;
  logic last;

  always_comb begin
    st_d = st_q;
    last = 1'b0;
    unique case (st_q)
      ST_PRE0:     st_d = is_ddr2_i ? ST_EMR2 : ST_EMR_DLL;
      ST_EMR2:     st_d = ST_EMR3;
      ST_EMR3:     st_d = ST_EMR_DLL;
      ST_EMR_DLL:  st_d = ST_MR_RST;
      ST_MR_RST:   st_d = ST_PRE1;
      ST_PRE1:     st_d = ST_AREF0;
      ST_AREF0:    st_d = ST_AREF1;
      ST_AREF1:    st_d = ST_MR_FIN;
      ST_MR_FIN: begin
        st_d = is_ddr2_i ? ST_OCD_DEF : ST_DONE;
        last = !is_ddr2_i;
      end
      ST_OCD_DEF:  st_d = ST_OCD_EXIT;
      ST_OCD_EXIT: begin
        st_d = ST_DONE;
        last = 1'b1;
      end
      default:     st_d = st_q;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= ST_IDLE;
    end else if ((st_q == ST_IDLE || st_q == ST_DONE) && go_i) begin
      st_q <= ST_PRE0;
    end else if (valid_o && ack_i) begin
      st_q <= st_d;
    end
  end

  always_comb begin
    kind   = CMD_MODE;
    bank_o = BANK_MR;
    data_o = '0;
    unique case (st_q)
      ST_PRE0, ST_PRE1:   kind = CMD_PREALL;
      ST_AREF0, ST_AREF1: kind = CMD_AREF;
      ST_EMR2:            bank_o = BANK_EMR2;
      ST_EMR3:            bank_o = BANK_EMR3;
      ST_EMR_DLL:         bank_o = BANK_EMR;
      ST_MR_RST:          data_o = MR_BL8 | MR_DLL_RST;
      ST_MR_FIN: begin
        data_o = MR_BL8 | (MODE_W'(cas_i) << MR_CAS_LSB);
        if (is_ddr2_i) data_o = data_o | (MODE_W'(wr_i - 4'd1) << MR_WR_LSB);
      end
      ST_OCD_DEF: begin
        bank_o = BANK_EMR;
        data_o = EMR_WEAK | EMR_OCD_DEF | EMR_NDQS;
      end
      ST_OCD_EXIT: begin
        bank_o = BANK_EMR;
        data_o = EMR_WEAK | EMR_NDQS;
      end
      default:            kind = CMD_NONE;
    endcase
  end

  assign kind_o  = kind;
  assign valid_o = (kind != CMD_NONE);
  assign busy_o  = (st_q != ST_IDLE) && (st_q != ST_DONE);
  assign done_o  = (st_q == ST_DONE);
  assign fin_o   = valid_o && ack_i && last;

endmodule

// File: rtl/ddr_init_seq.sv
module ddr_init_seq
  import ddr_init_pkg::*;
#(
  parameter int CLK_W        = 12,
  parameter int TRP_W        = 4,
  parameter int TRFC_W       = 6,
  parameter int PER_W        = 10,
  parameter int REF_PER_40   = 312,
  parameter int REF_PER_25   = 195,
  parameter int DDR1_MIN_MHZ = 400,
  parameter int DDR2_MIN_MHZ = 533
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              is_ddr2_i,
  input  logic [CLK_W-1:0]  clk_mhz_i,
  input  logic              xtal_40_i,
  input  logic              cas_fix_en_i,
  input  logic [2:0]        cas_fix_i,
  output logic              cmd_valid_o,
  output logic [1:0]        cmd_kind_o,
  output logic [1:0]        cmd_bank_o,
  output logic [12:0]       cmd_data_o,
  input  logic              cmd_ack_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              ref_en_o,
  output logic [PER_W-1:0]  ref_period_o,
  output logic [2:0]        cas_lat_o,
  output logic [TRP_W-1:0]  trp_cyc_o,
  output logic [TRFC_W-1:0] trfc_cyc_o
);
  logic [2:0]        cas_c;
  logic [CLK_W-1:0]  clk_eff;
  logic [TRP_W-1:0]  trp_c;
  logic [TRFC_W-1:0] trfc_c;
  logic [3:0]        wr_c;
  logic              go, fin;

  logic              ddr2_q;
  logic [3:0]        wr_q;
  logic [PER_W-1:0]  per_q;
  logic              ref_q;

  ddr_cas_sel #(
    .CLK_W(CLK_W), .DDR1_MIN_MHZ(DDR1_MIN_MHZ), .DDR2_MIN_MHZ(DDR2_MIN_MHZ)
  ) u_cas (
    .is_ddr2_i    (is_ddr2_i),
    .clk_mhz_i    (clk_mhz_i),
    .cas_fix_en_i (cas_fix_en_i),
    .cas_fix_i    (cas_fix_i),
    .cas_o        (cas_c),
    .clk_eff_o    (clk_eff)
  );

  ddr_timing_calc #(
    .CLK_W(CLK_W), .TRP_W(TRP_W), .TRFC_W(TRFC_W)
  ) u_tim (
    .is_ddr2_i (is_ddr2_i),
    .clk_eff_i (clk_eff),
    .trp_o     (trp_c),
    .trfc_o    (trfc_c),
    .wr_o      (wr_c)
  );

  assign go = start_i && !busy_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ddr2_q     <= 1'b0;
      cas_lat_o  <= '0;
      wr_q       <= '0;
      trp_cyc_o  <= '0;
      trfc_cyc_o <= '0;
      per_q      <= '0;
    end else if (go) begin
      ddr2_q     <= is_ddr2_i;
      cas_lat_o  <= cas_c;
      wr_q       <= wr_c;
      trp_cyc_o  <= trp_c;
      trfc_cyc_o <= trfc_c;
      per_q      <= xtal_40_i ? PER_W'(REF_PER_40) : PER_W'(REF_PER_25);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)  ref_q <= 1'b0;
    else if (go)  ref_q <= 1'b0;
    else if (fin) ref_q <= 1'b1;
  end

  assign ref_en_o     = ref_q;
  assign ref_period_o = per_q;

  ddr_cmd_seq u_seq (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .go_i      (go),
    .is_ddr2_i (ddr2_q),
    .cas_i     (cas_lat_o),
    .wr_i      (wr_q),
    .ack_i     (cmd_ack_i),
    .valid_o   (cmd_valid_o),
    .kind_o    (cmd_kind_o),
    .bank_o    (cmd_bank_o),
    .data_o    (cmd_data_o),
    .busy_o    (busy_o),
    .done_o    (done_o),
    .fin_o     (fin)
  );

endmodule

// File: rtl/ddr_init_seq_chk.sv
module ddr_init_seq_chk #(
  parameter int PER_W = 10
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             start_i,
  input logic             busy_o,
  input logic             done_o,
  input logic             cmd_valid_o,
  input logic             cmd_ack_i,
  input logic [1:0]       cmd_kind_o,
  input logic [1:0]       cmd_bank_o,
  input logic [12:0]      cmd_data_o,
  input logic             ref_en_o,
  input logic [PER_W-1:0] ref_period_o
);
  a_r8_hold_until_ack: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_o && !cmd_ack_i) |=> (cmd_valid_o && $stable(cmd_kind_o)
      && $stable(cmd_bank_o) && $stable(cmd_data_o)));

  a_r9_idle_when_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !cmd_valid_o);

  a_r9_ref_with_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ref_en_o |-> done_o);

  a_r9_ref_period: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ref_en_o |-> (ref_period_o == PER_W'(312) || ref_period_o == PER_W'(195)));

  a_r5_first_preall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o) |=> (cmd_valid_o && cmd_kind_o == 2'd1));

  a_r11_busy_no_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> !done_o);

endmodule

bind ddr_init_seq ddr_init_seq_chk #(.PER_W(PER_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .start_i      (start_i),
  .busy_o       (busy_o),
  .done_o       (done_o),
  .cmd_valid_o  (cmd_valid_o),
  .cmd_ack_i    (cmd_ack_i),
  .cmd_kind_o   (cmd_kind_o),
  .cmd_bank_o   (cmd_bank_o),
  .cmd_data_o   (cmd_data_o),
  .ref_en_o     (ref_en_o),
  .ref_period_o (ref_period_o)
);

// File: tb/tb_ddr_init_seq.sv
`timescale 1ns/1ps
module tb_ddr_init_seq;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0;
  logic        is_ddr2_i = 1'b0;
  logic [11:0] clk_mhz_i = '0;
  logic        xtal_40_i = 1'b0;
  logic        cas_fix_en_i = 1'b0;
  logic [2:0]  cas_fix_i = '0;
  logic        cmd_valid_o;
  logic [1:0]  cmd_kind_o, cmd_bank_o;
  logic [12:0] cmd_data_o;
  logic        cmd_ack_i = 1'b0;
  logic        busy_o, done_o, ref_en_o;
  logic [9:0]  ref_period_o;
  logic [2:0]  cas_lat_o;
  logic [3:0]  trp_cyc_o;
  logic [5:0]  trfc_cyc_o;

  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  always #4 clk_i = ~clk_i;

  ddr_init_seq dut (.*);

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int exp_cas(bit d2, int mhz, bit fen, int fv);
    if (fen) return fv;
    if (!d2) return (mhz <= 266) ? 2 : 3;
    if (mhz <= 400) return 3;
    if (mhz <= 533) return 4;
    if (mhz <= 666) return 5;
    if (mhz <= 800) return 6;
    return 7;
  endfunction

  function automatic int sat(int v, int m);
    return (v > m) ? m : v;
  endfunction

  // full sequence with a responder that delays each ack by dly cycles
  task automatic run_seq(string req, bit d2, int mhz, bit x40, bit fen, int fv,
                         int dly, bit poke);
    int ek[16], eb[16], ed[16];
    int gk[16], gb[16], gd[16];
    int ne = 0, ng = 0, cyc = 0, wt = 0;
    int cas, c, wr;
    int hk = 0, hb = 0, hd = 0;
    cas = exp_cas(d2, mhz, fen, fv);
    c   = d2 ? ((mhz < 533) ? 533 : mhz) : ((mhz < 400) ? 400 : mhz);
    wr  = sat((15 * c + 1000) / 2000, 8);
    ek[ne] = 1; eb[ne] = 0; ed[ne] = 0; ne++;
    if (d2) begin
      ek[ne] = 3; eb[ne] = 2; ed[ne] = 0; ne++;
      ek[ne] = 3; eb[ne] = 3; ed[ne] = 0; ne++;
    end
    ek[ne] = 3; eb[ne] = 1; ed[ne] = 0; ne++;
    ek[ne] = 3; eb[ne] = 0; ed[ne] = 'h103; ne++;
    ek[ne] = 1; eb[ne] = 0; ed[ne] = 0; ne++;
    ek[ne] = 2; eb[ne] = 0; ed[ne] = 0; ne++;
    ek[ne] = 2; eb[ne] = 0; ed[ne] = 0; ne++;
    ek[ne] = 3; eb[ne] = 0; ed[ne] = 3 | (cas << 4) | (d2 ? ((wr - 1) << 9) : 0); ne++;
    if (d2) begin
      ek[ne] = 3; eb[ne] = 1; ed[ne] = 'h782; ne++;
      ek[ne] = 3; eb[ne] = 1; ed[ne] = 'h402; ne++;
    end

    @(negedge clk_i);
    is_ddr2_i = d2; clk_mhz_i = 12'(mhz); xtal_40_i = x40;
    cas_fix_en_i = fen; cas_fix_i = 3'(fv);
    start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    while (!done_o && cyc < 2000) begin
      if (poke && cyc == 4) begin
        start_i = 1'b1; is_ddr2_i = !d2; clk_mhz_i = 12'd9; xtal_40_i = !x40;
      end else begin
        start_i = 1'b0;
      end
      if (cmd_ack_i) begin
        cmd_ack_i = 1'b0;
        wt = 0;
      end else if (cmd_valid_o) begin
        if (wt == 0) begin
          hk = cmd_kind_o; hb = cmd_bank_o; hd = cmd_data_o;
        end else begin
          chk({req, " R8 held kind"}, cmd_kind_o, hk);
          chk({req, " R8 held code"}, cmd_data_o, hd);
        end
        if (wt >= dly) begin
          if (ng < 16) begin
            gk[ng] = cmd_kind_o; gb[ng] = cmd_bank_o; gd[ng] = cmd_data_o;
          end
          ng++;
          cmd_ack_i = 1'b1;
        end
        wt++;
      end
      @(negedge clk_i);
      cyc++;
    end
    cmd_ack_i = 1'b0;
    start_i = 1'b0;
    chk({req, " R9 done"}, done_o, 1);
    chk({req, " R9 refresh enable"}, ref_en_o, 1);
    chk({req, " R9 no command when done"}, cmd_valid_o, 0);
    chk({req, " R9 refresh period"}, ref_period_o, x40 ? 312 : 195);
    chk({req, " R8 command count"}, ng, ne);
    for (int i = 0; i < ne && i < ng; i++) begin
      chk({req, d2 ? " R6 kind" : " R5 kind"}, gk[i], ek[i]);
      chk({req, d2 ? " R6 bank" : " R5 bank"}, gb[i], eb[i]);
      chk({req, " R7 code"}, gd[i], ed[i]);
    end
    chk({req, " cas latency"}, cas_lat_o, cas);
    chk({req, " R10 precharge count"}, trp_cyc_o, sat((15 * c + 500) / 1000, 15));
    chk({req, " R10 refresh-cycle count"}, trfc_cyc_o,
        sat(((d2 ? 120 : 75) * c + 500) / 1000, 63));
  endtask

  task automatic t_reset();
    chk("R1 valid", cmd_valid_o, 0);
    chk("R1 busy", busy_o, 0);
    chk("R1 done", done_o, 0);
    chk("R1 refresh enable", ref_en_o, 0);
  endtask

  task automatic t_ddr1();
    run_seq("R2 R5 ddr1 200", 0, 200, 0, 0, 0, 0, 0);
    run_seq("R2 R5 ddr1 266", 0, 266, 1, 0, 0, 1, 0);
    run_seq("R2 R5 ddr1 267", 0, 267, 1, 0, 0, 0, 0);
  endtask

  task automatic t_ddr2();
    run_seq("R3 R6 ddr2 400", 1, 400, 1, 0, 0, 3, 0);
    run_seq("R3 ddr2 401", 1, 401, 0, 0, 0, 0, 0);
    run_seq("R3 ddr2 533", 1, 533, 0, 0, 0, 0, 0);
    run_seq("R3 ddr2 534", 1, 534, 0, 0, 0, 0, 0);
    run_seq("R3 R10 ddr2 600", 1, 600, 1, 0, 0, 2, 0);
    run_seq("R3 ddr2 666", 1, 666, 0, 0, 0, 0, 0);
    run_seq("R3 ddr2 667", 1, 667, 0, 0, 0, 0, 0);
    run_seq("R3 ddr2 800", 1, 800, 0, 0, 0, 0, 0);
    run_seq("R3 R7 ddr2 1200 saturate", 1, 1200, 0, 0, 0, 0, 0);
  endtask

  task automatic t_fixed();
    run_seq("R4 ddr1 forced 5", 0, 200, 0, 1, 5, 0, 0);
    run_seq("R4 ddr2 forced 3", 1, 900, 1, 1, 3, 0, 0);
  endtask

  task automatic t_busy_start();
    run_seq("R11 start while busy", 1, 500, 1, 0, 0, 1, 1);
    run_seq("R11 start while busy ddr1", 0, 350, 0, 0, 0, 0, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    t_reset();
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    t_ddr1();
    t_ddr2();
    t_fixed();
    t_busy_start();
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!finished) begin
      finished = 1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

endmodule